// File: doc/BRIEF.md
# Atomic Reservation Lock Unit

This block keeps a small table of line reservations that make split read-modify-write atomics safe. When the read half of an atomic completes, the line it touched is reserved for the requesting processor, identified by a numeric requester ID. When the write half completes, the block decides at once whether the atomic succeeded. It succeeds only if the same requester still holds the reservation on that line, and a success releases the reservation. A failed write leaves the table as it was.

Reservations belong to the data side only. Completions flagged as coming from the instruction side, and plain loads and stores, pass through without touching the table. A separate clear strobe drops a reservation on a line, so that an invalidation or eviction elsewhere can break it. The table has a fixed number of entries. A new line takes the lowest free entry. When no entry is free, it takes the entry whose reservation was placed longest ago. A lookup port reports whether any line is reserved, and by whom.

Top module: `rsv_lock_unit`

## Requirements
- R1: After reset no line is reserved: the lookup reports `look_locked`=0 for every line, and `atom_done` and `atom_ok` are 0.
- R2: A data-side completion with `cpl_kind`=2'b10 (atomic read) reserves `cpl_line` for `cpl_owner`, visible from the next cycle. If that line is already reserved, its owner is replaced and the reservation counts as the newest.
- R3: A data-side completion with `cpl_kind`=2'b11 (atomic write) on a line reserved by the same `cpl_owner` raises `atom_done` and `atom_ok` in the same cycle as the strobe. The reservation is gone from the next cycle.
- R4: An atomic write on a line that is unreserved, or reserved by another requester, raises `atom_done` with `atom_ok`=0 and leaves every reservation and owner unchanged.
- R5: Completions with `cpl_ifetch`=1, and completions with `cpl_kind`=2'b00 (load) or 2'b01 (store), change no reservation and raise no `atom_done`.
- R6: A new line fills a free entry when one exists, so that no reservation is lost. When all `ENTRIES` entries hold reservations, the new line replaces the reservation placed or refreshed longest ago.
- R7: `clr_valid` drops any reservation on `clr_line` from the next cycle, and has no effect on other lines. If it falls in the same cycle as an atomic read of the same line, the line ends unreserved.
- R8: `atom_done` and `atom_ok` are high only in cycles with a qualifying atomic write strobe, so each completion gives a single-cycle pulse. `atom_ok` is never high without `atom_done`.
- R9: The lookup is combinational. In the same cycle, `look_locked` and `look_owner` reflect the table state for `look_line`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpl_valid | input | 1 | Completion strobe |
| cpl_kind | input | 2 | 00 load, 01 store, 10 atomic read, 11 atomic write |
| cpl_ifetch | input | 1 | Completion belongs to the instruction side |
| cpl_line | input | LINE_W | Line address of the completion |
| cpl_owner | input | ID_W | Requester ID of the completion |
| clr_valid | input | 1 | Drop the reservation on clr_line |
| clr_line | input | LINE_W | Line whose reservation is dropped |
| look_line | input | LINE_W | Line to query |
| look_locked | output | 1 | look_line is reserved |
| look_owner | output | ID_W | Owner of look_line (0 when not reserved) |
| atom_done | output | 1 | An atomic write completed this cycle |
| atom_ok | output | 1 | That atomic write succeeded |

## Verification
The bench probes an owner mismatch after a reservation has been taken over, and checks that the failed write did not release the other requester's hold. A design that released on any write would break the holder's atomic. The capacity test frees an entry before filling the table, then refreshes one line before an eviction. A design that replaced by entry index, or ignored the refresh, would evict the wrong line. It also puts a clear and an atomic read of the same line in one cycle, where the wrong priority leaves a stale reservation. Instruction-side strobes and plain loads and stores hit a reserved line, to catch a decoder that treats any strobe as an atomic.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
   typedef enum logic [1:0] {
      CPL_LOAD    = 2'b00,
      CPL_STORE   = 2'b01,
      CPL_ATOM_RD = 2'b10,
      CPL_ATOM_WR = 2'b11
   } cpl_kind_e;
endpackage

// File: rtl/rsv_match.sv
// Compares one key against every table entry and returns a hit vector.
module rsv_match #(
   parameter int ENTRIES = 4,
   parameter int LINE_W  = 32
) (
   input  logic [ENTRIES-1:0]             valid,
   input  logic [ENTRIES-1:0][LINE_W-1:0] lines,
   input  logic [LINE_W-1:0]              key,
   output logic [ENTRIES-1:0]             hit
);
   for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
      assign hit[e] = valid[e] && (lines[e] == key);
   end
endmodule

// File: rtl/rsv_age.sv
// Pairwise age matrix: older_q[i][j] set means entry i was touched before j.
module rsv_age #(
   parameter int ENTRIES = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               touch_en,
   input  logic [ENTRIES-1:0] touch_vec,
   output logic [ENTRIES-1:0] oldest
);
   logic [ENTRIES-1:0][ENTRIES-1:0] older_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < ENTRIES; i++)
            for (int j = 0; j < ENTRIES; j++)
               older_q[i][j] <= (i < j);
      end else if (touch_en) begin
         for (int i = 0; i < ENTRIES; i++)
            for (int j = 0; j < ENTRIES; j++)
               if (i != j) begin
                  if (touch_vec[i])      older_q[i][j] <= 1'b0;
                  else if (touch_vec[j]) older_q[i][j] <= 1'b1;
               end
      end
   end

   always_comb begin
      for (int i = 0; i < ENTRIES; i++) begin
         oldest[i] = 1'b1;
         for (int j = 0; j < ENTRIES; j++)
            if (j != i && !older_q[i][j]) oldest[i] = 1'b0;
      end
   end

   p_oldest_unique_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(oldest));
endmodule

// File: rtl/rsv_pick.sv
// Chooses the entry for a new line: lowest free one, else the oldest.
module rsv_pick #(
   parameter int ENTRIES = 4
) (
   input  logic [ENTRIES-1:0] valid,
   input  logic [ENTRIES-1:0] oldest,
   output logic [ENTRIES-1:0] pick
);
   logic [ENTRIES-1:0] free_vec;
   logic [ENTRIES-1:0] low_free;

   assign free_vec = ~valid;
   assign low_free = free_vec & (~free_vec + {{(ENTRIES-1){1'b0}}, 1'b1});
   assign pick     = (|free_vec) ? low_free : oldest;
endmodule

// File: rtl/rsv_lock_unit.sv
module rsv_lock_unit #(
   parameter int ENTRIES = 4,
   parameter int LINE_W  = 32,
   parameter int ID_W    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpl_valid,
   input  logic [1:0]        cpl_kind,
   input  logic              cpl_ifetch,
   input  logic [LINE_W-1:0] cpl_line,
   input  logic [ID_W-1:0]   cpl_owner,
   input  logic              clr_valid,
   input  logic [LINE_W-1:0] clr_line,
   input  logic [LINE_W-1:0] look_line,
   output logic              look_locked,
   output logic [ID_W-1:0]   look_owner,
   output logic              atom_done,
   output logic              atom_ok
);
   import rsv_pkg::*;

   if (ENTRIES < 2 || ENTRIES > 16) begin : g_bad_entries
      $error("rsv_lock_unit: ENTRIES must lie in 2..16");
   end
   if (LINE_W < 1 || ID_W < 1) begin : g_bad_width
      $error("rsv_lock_unit: LINE_W and ID_W must be positive");
   end

   cpl_kind_e kind;
   assign kind = cpl_kind_e'(cpl_kind);

   logic [ENTRIES-1:0]             valid_q, valid_n;
   logic [ENTRIES-1:0][LINE_W-1:0] line_q, line_n;
   logic [ENTRIES-1:0][ID_W-1:0]   owner_q, owner_n;

   logic is_rd, is_wr;
   assign is_rd = cpl_valid && !cpl_ifetch && (kind == CPL_ATOM_RD);
   assign is_wr = cpl_valid && !cpl_ifetch && (kind == CPL_ATOM_WR);

   logic [ENTRIES-1:0] hit_cpl, hit_look, hit_own, oldest, pick, target;

   rsv_match #(.ENTRIES(ENTRIES), .LINE_W(LINE_W)) i_match_cpl (
      .valid(valid_q), .lines(line_q), .key(cpl_line), .hit(hit_cpl));
   rsv_match #(.ENTRIES(ENTRIES), .LINE_W(LINE_W)) i_match_look (
      .valid(valid_q), .lines(line_q), .key(look_line), .hit(hit_look));

   for (genvar e = 0; e < ENTRIES; e++) begin : g_own
      assign hit_own[e] = hit_cpl[e] && (owner_q[e] == cpl_owner);
   end

   rsv_age #(.ENTRIES(ENTRIES)) i_age (
      .clk(clk), .rst_n(rst_n), .touch_en(is_rd), .touch_vec(target),
      .oldest(oldest));
   rsv_pick #(.ENTRIES(ENTRIES)) i_pick (
      .valid(valid_q), .oldest(oldest), .pick(pick));

   assign target    = (|hit_cpl) ? hit_cpl : pick;
   assign atom_done = is_wr;
   assign atom_ok   = is_wr && (|hit_own);

   always_comb begin
      valid_n = valid_q;
      line_n  = line_q;
      owner_n = owner_q;
      for (int e = 0; e < ENTRIES; e++) begin
         if (is_rd && target[e]) begin
            valid_n[e] = 1'b1;
            line_n[e]  = cpl_line;
            owner_n[e] = cpl_owner;
         end
         if (is_wr && hit_own[e]) valid_n[e] = 1'b0;
         if (clr_valid && valid_n[e] && line_n[e] == clr_line) valid_n[e] = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= '0;
         line_q  <= '0;
         owner_q <= '0;
      end else begin
         valid_q <= valid_n;
         line_q  <= line_n;
         owner_q <= owner_n;
      end
   end

   always_comb begin
      look_owner = '0;
      for (int e = 0; e < ENTRIES; e++)
         if (hit_look[e]) look_owner = look_owner | owner_q[e];
   end
   assign look_locked = |hit_look;

   // ---------------- assertions ----------------
   logic              chk_rd_q, chk_ok_q, chk_clr_q;
   logic [LINE_W-1:0] chk_line_q, chk_clr_line_q;
   logic [ID_W-1:0]   chk_id_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chk_rd_q       <= 1'b0;
         chk_ok_q       <= 1'b0;
         chk_clr_q      <= 1'b0;
         chk_line_q     <= '0;
         chk_clr_line_q <= '0;
         chk_id_q       <= '0;
      end else begin
         chk_rd_q       <= is_rd && !(clr_valid && clr_line == cpl_line);
         chk_ok_q       <= atom_ok;
         chk_clr_q      <= clr_valid;
         chk_line_q     <= cpl_line;
         chk_clr_line_q <= clr_line;
         chk_id_q       <= cpl_owner;
      end
   end

   logic [ENTRIES-1:0] chk_hit_line, chk_hit_clr;
   rsv_match #(.ENTRIES(ENTRIES), .LINE_W(LINE_W)) i_match_chk (
      .valid(valid_q), .lines(line_q), .key(chk_line_q), .hit(chk_hit_line));
   rsv_match #(.ENTRIES(ENTRIES), .LINE_W(LINE_W)) i_match_chk_clr (
      .valid(valid_q), .lines(line_q), .key(chk_clr_line_q), .hit(chk_hit_clr));

   logic [ENTRIES-1:0] chk_owned;
   logic               dup_line;
   always_comb begin
      dup_line = 1'b0;
      for (int i = 0; i < ENTRIES; i++) begin
         chk_owned[i] = chk_hit_line[i] && owner_q[i] == chk_id_q;
         for (int j = i + 1; j < ENTRIES; j++)
            if (valid_q[i] && valid_q[j] && line_q[i] == line_q[j]) dup_line = 1'b1;
      end
   end

   p_lock_taken_r2: assert property (@(posedge clk) disable iff (!rst_n)
      chk_rd_q |-> $countones(chk_owned) == 1);
   p_release_on_ok_r3: assert property (@(posedge clk) disable iff (!rst_n)
      chk_ok_q |-> chk_hit_line == '0);
   p_fail_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (is_wr && !atom_ok && !clr_valid) |=> ($stable(valid_q) && $stable(owner_q)));
   p_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cpl_valid && (cpl_ifetch || !cpl_kind[1]) && !clr_valid)
         |=> ($stable(valid_q) && $stable(owner_q)));
   p_unique_line_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !dup_line);
   p_clear_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
      chk_clr_q |-> chk_hit_clr == '0);
endmodule

// File: tb/test_rsv_lock_unit.sv
`timescale 1ns/100ps
module test_rsv_lock_unit;
   localparam int LW = 32;
   localparam int IW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cpl_valid = 1'b0;
   logic [1:0]    cpl_kind = 2'b00;
   logic          cpl_ifetch = 1'b0;
   logic [LW-1:0] cpl_line = '0;
   logic [IW-1:0] cpl_owner = '0;
   logic          clr_valid = 1'b0;
   logic [LW-1:0] clr_line = '0;
   logic [LW-1:0] look_line = '0;
   logic          look_locked, atom_done, atom_ok;
   logic [IW-1:0] look_owner;

   int checks = 0;
   int fails  = 0;
   bit ended  = 1'b0;

   always #2.5 clk = ~clk;

   rsv_lock_unit #(.ENTRIES(4), .LINE_W(LW), .ID_W(IW)) i_rsv_lock_unit (
      .clk(clk), .rst_n(rst_n), .cpl_valid(cpl_valid), .cpl_kind(cpl_kind),
      .cpl_ifetch(cpl_ifetch), .cpl_line(cpl_line), .cpl_owner(cpl_owner),
      .clr_valid(clr_valid), .clr_line(clr_line), .look_line(look_line),
      .look_locked(look_locked), .look_owner(look_owner),
      .atom_done(atom_done), .atom_ok(atom_ok));

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Drives one completion (optionally with a clear) for one cycle; samples pulses.
   task automatic cpl(input logic [1:0] k, input logic ifc, input logic [LW-1:0] ln,
                      input logic [IW-1:0] id, input logic clr, input logic [LW-1:0] cln,
                      output logic d, output logic o);
      @(negedge clk);
      cpl_valid = 1'b1; cpl_kind = k; cpl_ifetch = ifc; cpl_line = ln; cpl_owner = id;
      clr_valid = clr; clr_line = cln;
      #1;
      d = atom_done; o = atom_ok;
      @(negedge clk);
      cpl_valid = 1'b0; clr_valid = 1'b0; cpl_ifetch = 1'b0;
   endtask

   task automatic lock(input logic [LW-1:0] ln, input logic [IW-1:0] id);
      logic d, o;
      cpl(2'b10, 1'b0, ln, id, 1'b0, '0, d, o);
   endtask

   task automatic clear(input logic [LW-1:0] ln);
      @(negedge clk);
      clr_valid = 1'b1; clr_line = ln;
      @(negedge clk);
      clr_valid = 1'b0;
   endtask

   task automatic expect_lock(input logic [LW-1:0] ln, input logic lk,
                              input logic [IW-1:0] id, input string req);
      look_line = ln;
      #1;
      check(look_locked == lk, req, look_locked, lk);
      if (lk) check(look_owner == id, req, look_owner, id);
   endtask

   task automatic t_reset;
      #1;
      check(atom_done == 1'b0 && atom_ok == 1'b0, "R1 pulses idle", {atom_done, atom_ok}, 0);
      expect_lock(32'h100, 1'b0, 0, "R1 no lock");
      expect_lock(32'h0, 1'b0, 0, "R1 no lock line0");
   endtask

   task automatic t_lock_and_succeed;
      logic d, o;
      lock(32'h100, 4'd3);
      expect_lock(32'h100, 1'b1, 4'd3, "R2 lock taken");
      expect_lock(32'h104, 1'b0, 0, "R9 other line free");
      cpl(2'b11, 1'b0, 32'h100, 4'd3, 1'b0, '0, d, o);
      check(d && o, "R3 write success pulse", {d, o}, 3);
      #1;
      check(!atom_done && !atom_ok, "R8 pulse one cycle", {atom_done, atom_ok}, 0);
      expect_lock(32'h100, 1'b0, 0, "R3 released");
   endtask

   task automatic t_fail_paths;
      logic d, o;
      lock(32'h200, 4'd1);
      cpl(2'b11, 1'b0, 32'h200, 4'd2, 1'b0, '0, d, o);
      check(d && !o, "R4 wrong owner fails", {d, o}, 2);
      expect_lock(32'h200, 1'b1, 4'd1, "R4 lock kept");
      cpl(2'b11, 1'b0, 32'h300, 4'd1, 1'b0, '0, d, o);
      check(d && !o, "R4 unlocked line fails", {d, o}, 2);
      expect_lock(32'h200, 1'b1, 4'd1, "R4 lock kept after miss");
      cpl(2'b11, 1'b0, 32'h200, 4'd1, 1'b0, '0, d, o);
      check(d && o, "R3 holder succeeds", {d, o}, 3);
   endtask

   task automatic t_relock;
      logic d, o;
      lock(32'h400, 4'd5);
      lock(32'h400, 4'd6);
      expect_lock(32'h400, 1'b1, 4'd6, "R2 owner replaced");
      cpl(2'b11, 1'b0, 32'h400, 4'd5, 1'b0, '0, d, o);
      check(d && !o, "R4 old owner fails", {d, o}, 2);
      expect_lock(32'h400, 1'b1, 4'd6, "R4 new owner kept");
   endtask

   task automatic t_ignored;
      logic d, o;
      cpl(2'b10, 1'b1, 32'h500, 4'd2, 1'b0, '0, d, o);
      check(!d, "R5 ifetch read no pulse", d, 0);
      expect_lock(32'h500, 1'b0, 0, "R5 ifetch read no lock");
      cpl(2'b11, 1'b1, 32'h400, 4'd6, 1'b0, '0, d, o);
      check(!d && !o, "R5 ifetch write no pulse", {d, o}, 0);
      expect_lock(32'h400, 1'b1, 4'd6, "R5 ifetch write keeps lock");
      cpl(2'b00, 1'b0, 32'h400, 4'd7, 1'b0, '0, d, o);
      check(!d, "R5 load no pulse", d, 0);
      cpl(2'b01, 1'b0, 32'h400, 4'd6, 1'b0, '0, d, o);
      check(!d, "R5 store no pulse", d, 0);
      expect_lock(32'h400, 1'b1, 4'd6, "R5 plain ops keep lock");
   endtask

   task automatic t_clear;
      logic d, o;
      lock(32'h600, 4'd4);
      clear(32'h700);
      expect_lock(32'h600, 1'b1, 4'd4, "R7 other clear no effect");
      clear(32'h600);
      expect_lock(32'h600, 1'b0, 0, "R7 clear drops");
      cpl(2'b10, 1'b0, 32'h800, 4'd4, 1'b1, 32'h800, d, o);
      expect_lock(32'h800, 1'b0, 0, "R7 clear beats same-cycle lock");
      clear(32'h200); clear(32'h400);
      expect_lock(32'h400, 1'b0, 0, "R7 table emptied");
   endtask

   task automatic t_capacity;
      lock(32'hA0, 4'd1); lock(32'hA1, 4'd1); lock(32'hA2, 4'd1); lock(32'hA3, 4'd1);
      clear(32'hA1);
      lock(32'hA4, 4'd2);
      expect_lock(32'hA0, 1'b1, 4'd1, "R6 free slot used, no eviction");
      lock(32'hA5, 4'd2);
      expect_lock(32'hA0, 1'b0, 0, "R6 oldest evicted");
      expect_lock(32'hA2, 1'b1, 4'd1, "R6 younger kept");
      expect_lock(32'hA4, 1'b1, 4'd2, "R6 refill kept");
      expect_lock(32'hA5, 1'b1, 4'd2, "R6 newest present");
      lock(32'hA2, 4'd9);
      lock(32'hA6, 4'd3);
      expect_lock(32'hA3, 1'b0, 0, "R6 oldest after refresh evicted");
      expect_lock(32'hA2, 1'b1, 4'd9, "R6 refreshed line kept");
      expect_lock(32'hA6, 1'b1, 4'd3, "R6 new line present");
   endtask

   initial begin
      #(5.0 * 100000);
      if (!ended) begin
         ended = 1'b1;
         checks++; fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset;
      t_lock_and_succeed;
      t_fail_paths;
      t_relock;
      t_ignored;
      t_clear;
      t_capacity;
      if (!ended) begin
         ended = 1'b1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule